// File: doc/BRIEF.md
# Link Status Config Word Handshake

This block runs on the PHY side of a serial MAC-to-PHY link. It tells the MAC the copper PHY's current link state, duplex and speed through a 16-bit configuration word. The exchange is a trimmed-down version of the clause 37 auto-negotiation exchange. The block samples the three status inputs and builds a word from them. It raises a flag that tells the transmit encoder to send configuration ordered sets in place of idles. It then waits for the MAC to return an acknowledging word. After the acknowledge it runs a link timer and finally reports that the exchange is complete.

If link, duplex or speed changes at any point, the block takes a fresh snapshot and starts the exchange again from the send phase. Received words arrive with a single-cycle valid strobe from the deserializer. There is no ready signal and no back-pressure: the block looks at every strobed word in the cycle it appears. The block acts on a strobed word only while it is waiting for the acknowledge.

The send phase length and the link timer length are parameters. The default link timer is 200,000 cycles, which gives 1.6 ms at 125 MHz.

Top module: `linkword_handshake`

## Requirements
- R1: While reset is asserted, `tx_cfg_en` and `done` are 0 and `tx_word` is 16'h0001.
- R2: The word layout is fixed. Bit 15 is link (1 = up), bit 12 is duplex (1 = full), bits 11:10 are the speed code and bit 0 is always 1. Bits 13 and 9:1 are always 0.
- R3: Bits 11:10 carry the speed input as given. The codes are 2'b10 for 1000 Mb/s, 2'b01 for 100 Mb/s and 2'b00 for 10 Mb/s. The reserved code 2'b11 is carried unchanged.
- R4: A received word counts as an acknowledge only when all of these hold: `rx_valid` is high, bit 14 is 1, bit 0 is 1, and the block is in the wait phase. A strobed word during the send phase has no effect, and so does a word missing either bit.
- R5: The send phase lasts exactly SEND_HOLD_CYCLES cycles, and the wait phase follows it. In both phases `tx_cfg_en` is 1, `done` is 0, and `tx_word` is held unchanged unless a status input changes.
- R6: Bit 14 of `tx_word` is 0 until an acknowledge is accepted. It reads 1 from the cycle after the accepting clock edge.
- R7: After an acknowledge the timer phase lasts exactly LINK_TIMER_CYCLES cycles with `tx_cfg_en` = 1. Then `done` goes to 1 and `tx_cfg_en` goes to 0, and both hold while the inputs stay the same.
- R8: When any of `link_up`, `full_duplex` or `speed_sel` differs from the last snapshot, the block restarts, whatever phase it is in. At the next edge it re-enters the send phase with the new values in the word and bit 14 cleared.
- R9: Once reset is released, the first clock edge starts the send phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Copper link is up |
| full_duplex | input | 1 | Copper link runs full duplex |
| speed_sel | input | 2 | Copper link speed code |
| rx_word | input | 16 | Config word received from the MAC |
| rx_valid | input | 1 | `rx_word` is valid this cycle (no back-pressure) |
| tx_word | output | 16 | Config word to transmit |
| tx_cfg_en | output | 1 | Send config ordered sets instead of idle |
| done | output | 1 | Exchange complete |

## Verification
The bench drives an acknowledge during the send phase. It also drives a word that has bit 14 but not bit 0, and a correct word with the strobe low. A design that accepted any of these would set bit 14 early and shorten the exchange.

It counts the send and timer phases cycle by cycle. An off-by-one counter would show `done` or the wait phase one cycle early or late.

It changes the status inputs once each in the done, wait and timer phases. A design that ignored a change, or that kept the old acknowledge bit after one, would transmit a stale word.

It also walks through all four speed codes, including the reserved one, to catch a wrong field mapping.

// File: rtl/lwh_pkg.sv
package lwh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_TIMER = 3'd3,
    ST_DONE  = 3'd4
  } lwh_state_e;

  typedef struct packed {
    logic       up;
    logic       full;
    logic [1:0] rate;
  } lwh_status_t;

  localparam int WORD_W  = 16;
  localparam int BIT_UP  = 15;
  localparam int BIT_ACK = 14;
  localparam int BIT_DUP = 12;
  localparam int BIT_RLO = 10;
  localparam int BIT_ONE = 0;

endpackage

// File: rtl/lwh_word_build.sv
module lwh_word_build
  import lwh_pkg::*;
(
  input  lwh_status_t       status,
  input  logic              ack_bit,
  output logic [WORD_W-1:0] word
);

  always_comb begin
    word                      = '0;
    word[BIT_UP]              = status.up;
    word[BIT_ACK]             = ack_bit;
    word[BIT_DUP]             = status.full;
    word[BIT_RLO+1:BIT_RLO]   = status.rate;
    word[BIT_ONE]             = 1'b1;
  end

endmodule

// File: rtl/lwh_change_detect.sv
module lwh_change_detect
  import lwh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  lwh_status_t live,
  output lwh_status_t snap,
  output logic        change
);

  assign change = (live != snap);

  always_ff @(posedge clk) begin
    if (!rst_n)      snap <= '0;
    else if (change) snap <= live;
  end

endmodule

// File: rtl/lwh_interval_counter.sv
module lwh_interval_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt;

  assign hit = run && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   cnt <= '0;
    else if (run && !hit) cnt <= cnt + CW'(1);
  end

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));

endmodule

// File: rtl/lwh_fsm.sv
module lwh_fsm
  import lwh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       change,
  input  logic       rx_valid,
  input  logic       rx_ack_bit,
  input  logic       rx_one_bit,
  input  logic       hit,
  output lwh_state_e state_q,
  output logic       ack_q,
  output logic       clr,
  output logic       run,
  output logic       sel_long
);

  lwh_state_e state_d;
  logic       ack_d;
  logic       ack_ok;

  assign ack_ok = rx_valid && rx_ack_bit && rx_one_bit;

  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    if (change) begin
      state_d = ST_SEND;
      ack_d   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_SEND;
        ST_SEND:  if (hit) state_d = ST_WAIT;
        ST_WAIT:  if (ack_ok) begin
                    state_d = ST_TIMER;
                    ack_d   = 1'b1;
                  end
        ST_TIMER: if (hit) state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign clr      = change || (state_d != state_q);
  assign run      = (state_q == ST_SEND) || (state_q == ST_TIMER);
  assign sel_long = (state_q == ST_TIMER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assert_ack_after_mac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(rx_valid && rx_ack_bit && rx_one_bit));

  assert_restart_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> (state_q == ST_SEND) && !ack_q);

  assert_done_from_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_DONE) |-> $past(state_q == ST_TIMER));

endmodule

// File: rtl/linkword_handshake.sv
module linkword_handshake
  import lwh_pkg::*;
#(
  parameter int SEND_HOLD_CYCLES  = 4,
  parameter int LINK_TIMER_CYCLES = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        full_duplex,
  input  logic [1:0]  speed_sel,
  input  logic [15:0] rx_word,
  input  logic        rx_valid,
  output logic [15:0] tx_word,
  output logic        tx_cfg_en,
  output logic        done
);

  localparam int MAXC = (SEND_HOLD_CYCLES > LINK_TIMER_CYCLES) ?
                        SEND_HOLD_CYCLES : LINK_TIMER_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  lwh_status_t live, snap;
  lwh_state_e  state_q;
  logic        change, ack_q, clr, run, sel_long, hit;
  logic [CW-1:0] limit;
  logic        unused_rx_bits;

  assign live = '{up: link_up, full: full_duplex, rate: speed_sel};
  assign unused_rx_bits = ^{rx_word[15], rx_word[13:1]};

  lwh_change_detect u_chg (
    .clk(clk), .rst_n(rst_n), .live(live), .snap(snap), .change(change)
  );

  lwh_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .change(change), .rx_valid(rx_valid),
    .rx_ack_bit(rx_word[BIT_ACK]), .rx_one_bit(rx_word[BIT_ONE]),
    .hit(hit), .state_q(state_q), .ack_q(ack_q), .clr(clr), .run(run),
    .sel_long(sel_long)
  );

  assign limit = sel_long ? CW'(LINK_TIMER_CYCLES) : CW'(SEND_HOLD_CYCLES);

  lwh_interval_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .limit(limit), .hit(hit)
  );

  lwh_word_build u_word (.status(snap), .ack_bit(ack_q), .word(tx_word));

  assign tx_cfg_en = (state_q == ST_SEND) || (state_q == ST_WAIT) ||
                     (state_q == ST_TIMER);
  assign done      = (state_q == ST_DONE);

  assert_word_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SEND || state_q == ST_WAIT) &&
     $past(state_q == ST_SEND || state_q == ST_WAIT) && !$past(change))
    |-> $stable(tx_word));

  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_cfg_en);

endmodule

// File: tb/linkword_handshake_bench.sv
module linkword_handshake_bench;

  localparam int HOLD = 3;
  localparam int LT   = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_up, full_duplex;
  logic [1:0]  speed_sel;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic [15:0] tx_word;
  logic        tx_cfg_en, done;

  always #5 clk = ~clk;

  linkword_handshake #(.SEND_HOLD_CYCLES(HOLD), .LINK_TIMER_CYCLES(LT)) u_linkword_handshake (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .full_duplex(full_duplex),
    .speed_sel(speed_sel), .rx_word(rx_word), .rx_valid(rx_valid),
    .tx_word(tx_word), .tx_cfg_en(tx_cfg_en), .done(done)
  );

  typedef struct {
    int          due;
    logic [15:0] w;
    logic        en;
    logic        dn;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] wd(input logic up, input logic fd,
                                     input logic [1:0] rt, input logic ak);
    return {up, ak, 1'b0, fd, rt, 9'b0, 1'b1};
  endfunction

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_cmp++;
      if (tx_word !== e.w || tx_cfg_en !== e.en || done !== e.dn) begin
        n_bad++;
        $display("FAIL %s: cycle %0d got word=%h en=%b done=%b expected word=%h en=%b done=%b",
                 e.tag, cyc, tx_word, tx_cfg_en, done, e.w, e.en, e.dn);
      end
    end
  end

  // driver: pushes the expected outputs for the next cycle, then advances
  task automatic tick(input logic [15:0] w, input logic en, input logic dn, input string tag);
    exp_t e;
    e.due = cyc + 1; e.w = w; e.en = en; e.dn = dn; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  task automatic send_and_wait(input logic [15:0] w, input string tag);
    tick(w, 1'b1, 1'b0, tag);
    for (int i = 1; i < HOLD; i++) tick(w, 1'b1, 1'b0, "R5 send phase held");
    tick(w, 1'b1, 1'b0, "R5 wait phase entered");
  endtask

  task automatic ack_and_finish(input logic [15:0] wa);
    rx_word = 16'h4001; rx_valid = 1'b1;
    tick(wa, 1'b1, 1'b0, "R6 ack bit set after accept");
    rx_valid = 1'b0;
    for (int i = 1; i < LT; i++) tick(wa, 1'b1, 1'b0, "R7 timer running");
    tick(wa, 1'b0, 1'b1, "R7 done after timer");
  endtask

  initial begin
    rst_n = 1'b0; link_up = 1'b1; full_duplex = 1'b1; speed_sel = 2'b10;
    rx_word = 16'h0000; rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    tick(16'h0001, 1'b0, 1'b0, "R1 reset state");

    // ack presented during send phase must be ignored (R4)
    rx_word = 16'h4001; rx_valid = 1'b1; rst_n = 1'b1;
    tick(16'h9801, 1'b1, 1'b0, "R9 send starts after reset");
    tick(16'h9801, 1'b1, 1'b0, "R2 1000 full word");
    tick(16'h9801, 1'b1, 1'b0, "R5 send phase held");
    rx_valid = 1'b0;
    tick(16'h9801, 1'b1, 1'b0, "R4 ack in send ignored");
    for (int i = 0; i < 4; i++) tick(16'h9801, 1'b1, 1'b0, "R5 wait holds");
    rx_word = 16'h4000; rx_valid = 1'b1;
    tick(16'h9801, 1'b1, 1'b0, "R4 bit0 missing ignored");
    rx_word = 16'h4001; rx_valid = 1'b0;
    tick(16'h9801, 1'b1, 1'b0, "R4 no strobe ignored");
    ack_and_finish(16'hD801);
    for (int i = 0; i < 3; i++) tick(16'hD801, 1'b0, 1'b1, "R7 done held");

    // change in done phase: speed to 100
    speed_sel = 2'b01;
    send_and_wait(16'h9401, "R8 restart from done");
    // change in wait phase: link down
    link_up = 1'b0;
    send_and_wait(16'h1401, "R8 restart from wait");
    // reserved speed code
    speed_sel = 2'b11;
    send_and_wait(16'h1C01, "R3 reserved code carried");
    rx_word = 16'h4001; rx_valid = 1'b1;
    tick(16'h5C01, 1'b1, 1'b0, "R6 ack bit set");
    rx_valid = 1'b0;
    for (int i = 0; i < 3; i++) tick(16'h5C01, 1'b1, 1'b0, "R7 timer running");
    // change in timer phase: 10 Mb/s half, link up
    link_up = 1'b1; full_duplex = 1'b0; speed_sel = 2'b00;
    send_and_wait(wd(1'b1, 1'b0, 2'b00, 1'b0), "R8 restart from timer clears ack");
    ack_and_finish(wd(1'b1, 1'b0, 2'b00, 1'b1));

    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule